// File: doc/BRIEF.md
# Operand Forwarding Select for an In-Order Pipeline

This block decides, for each of the two ALU operands of the instruction sitting in the execute stage, where that operand should come from. There are three candidate sources. The first is the value read from the register file. The second is the result held one stage downstream, the newest result in flight. The third is the result held two stages downstream, the oldest result in flight. The block compares each source register number of the execute-stage instruction with the destination numbers of the two in-flight results. From those comparisons it drives a 2-bit select per operand and also performs the three-way operand choice itself, so the selected operand values can be checked end to end.

The logic is purely combinational, and its outputs follow its inputs within the same cycle. Three rules govern every select:

- A result is only a forwarding candidate when its stage actually writes a register.
- A destination of register zero is never forwarded, because that register always reads as zero.
- When both in-flight results target the same source register, the newer one wins. A run of back-to-back accumulating instructions depends on this rule.

The register file is assumed to write early in the cycle and read late, so a result being written back in the current cycle reaches the operand through the register-file read. No extra path is needed for it.

Top module: `operand_forward`

## Requirements
- R1: Select for operand A is 2'b10 (newest result) whenever the newer stage writes a register, its destination is nonzero and equals the A source number.
- R2: Select for operand A is 2'b01 (older result) when the older stage writes a register, its destination is nonzero and equals the A source number, and the R1 condition does not hold.
- R3: Operand B follows the same rules as R1 and R2, using the B source number in place of the A source number.
- R4: When both stages qualify for the same source register, the select is 2'b10, so the newer result wins.
- R5: A destination of register 0 is never forwarded. A source number of 0 always yields select 2'b00. A newer stage whose destination is 0 does not block forwarding from the older stage.
- R6: A stage whose write-enable is low is never a forwarding source, even if its destination number matches.
- R7: Select 2'b00 (register-file value) is produced whenever no stage qualifies.
- R8: Each operand output equals the register-file value for select 2'b00, the newer result for 2'b10 and the older result for 2'b01.
- R9: The two operands are decided independently. In the same cycle, one operand may forward from one stage while the other forwards from the other stage.
- R10: The block holds no state. Its selects and operands reflect the current inputs without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_src_a | input | 5 | A source register number of the execute-stage instruction |
| ex_src_b | input | 5 | B source register number of the execute-stage instruction |
| new_wen | input | 1 | Newer in-flight result writes a register |
| new_dst | input | 5 | Destination register of the newer result |
| new_val | input | 32 | Value of the newer result |
| old_wen | input | 1 | Older in-flight result writes a register |
| old_dst | input | 5 | Destination register of the older result |
| old_val | input | 32 | Value of the older result |
| rf_val_a | input | 32 | Register-file read value for operand A |
| rf_val_b | input | 32 | Register-file read value for operand B |
| sel_a | output | 2 | Source select for operand A (00 file, 01 older, 10 newer) |
| sel_b | output | 2 | Source select for operand B (00 file, 01 older, 10 newer) |
| opnd_a | output | 32 | Selected value for operand A |
| opnd_b | output | 32 | Selected value for operand B |

## Verification
The case hardest to reach arises only when several conditions line up at once. The older stage holds a matching, enabled result, and the newer stage also claims a destination that must be rejected, either because its write-enable is low or because its destination is register 0. This checks that the priority rule does not let a disqualified newer stage shadow a valid older one. The stimulus table contains exactly these combinations, together with cross-wired cases where A and B take opposite stages in the same cycle. A sweep over every register number, including 0 and 31, then exercises the zero-register boundary from both stages.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

    typedef enum logic [1:0] {
        FWD_RF  = 2'b00,
        FWD_OLD = 2'b01,
        FWD_NEW = 2'b10
    } fwd_sel_e;

    localparam int NUM_OPND = 2;

endpackage

// File: rtl/fwd_hit.sv
module fwd_hit #(
    parameter int REG_W = 5
) (
    input  logic             wr_en,
    input  logic [REG_W-1:0] dst,
    input  logic [REG_W-1:0] src,
    output logic             hit
);

    typedef struct packed {
        logic writes;
        logic nonzero;
        logic same;
    } hit_terms_t;

    hit_terms_t terms_d;
    logic       hit_d;

    always_comb begin
        terms_d.writes  = wr_en;
        terms_d.nonzero = |dst;
        terms_d.same    = (dst == src);
        hit_d           = terms_d.writes & terms_d.nonzero & terms_d.same;
    end

    assign hit = hit_d;

endmodule

// File: rtl/fwd_pick.sv
module fwd_pick
    import fwd_pkg::*;
(
    input  logic     hit_new,
    input  logic     hit_old,
    output fwd_sel_e sel
);

    fwd_sel_e sel_d;

    always_comb begin
        sel_d = FWD_RF;
        if (hit_new) begin
            sel_d = FWD_NEW;
        end else if (hit_old) begin
            sel_d = FWD_OLD;
        end
    end

    assign sel = sel_d;

endmodule

// File: rtl/fwd_opmux.sv
module fwd_opmux
    import fwd_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  fwd_sel_e          sel,
    input  logic [DATA_W-1:0] rf_val,
    input  logic [DATA_W-1:0] new_val,
    input  logic [DATA_W-1:0] old_val,
    output logic [DATA_W-1:0] out_val
);

    logic [DATA_W-1:0] out_d;

    always_comb begin
        unique case (sel)
            FWD_NEW: out_d = new_val;
            FWD_OLD: out_d = old_val;
            default: out_d = rf_val;
        endcase
    end

    assign out_val = out_d;

endmodule

// File: rtl/fwd_operand.sv
module fwd_operand
    import fwd_pkg::*;
#(
    parameter int REG_W  = 5,
    parameter int DATA_W = 32
) (
    input  logic [REG_W-1:0]  src,
    input  logic              new_wen,
    input  logic [REG_W-1:0]  new_dst,
    input  logic [DATA_W-1:0] new_val,
    input  logic              old_wen,
    input  logic [REG_W-1:0]  old_dst,
    input  logic [DATA_W-1:0] old_val,
    input  logic [DATA_W-1:0] rf_val,
    output fwd_sel_e          sel,
    output logic [DATA_W-1:0] out_val
);

    logic hit_new;
    logic hit_old;

    fwd_hit #(.REG_W(REG_W)) u_hit_new (
        .wr_en (new_wen),
        .dst   (new_dst),
        .src   (src),
        .hit   (hit_new)
    );

    fwd_hit #(.REG_W(REG_W)) u_hit_old (
        .wr_en (old_wen),
        .dst   (old_dst),
        .src   (src),
        .hit   (hit_old)
    );

    fwd_pick u_pick (
        .hit_new (hit_new),
        .hit_old (hit_old),
        .sel     (sel)
    );

    fwd_opmux #(.DATA_W(DATA_W)) u_mux (
        .sel     (sel),
        .rf_val  (rf_val),
        .new_val (new_val),
        .old_val (old_val),
        .out_val (out_val)
    );

    // Port-level checks: the select is related back to the raw stage fields.
    always_comb begin
        if (sel == FWD_NEW) begin
            AST_NEW_SRC_QUALIFIES: assert (new_wen && (new_dst == src) && (src != '0)) else $error("newer select without a qualifying stage"); // R1
        end
        if (sel == FWD_OLD) begin
            AST_OLD_NOT_SHADOWED: assert (old_wen && (old_dst == src) && (src != '0) && !(new_wen && (new_dst == src))) else $error("older select while newer qualifies"); // R4
        end
        if (src == '0) begin
            AST_ZERO_REG_LOCAL: assert (sel == FWD_RF) else $error("register zero forwarded"); // R5
        end
        if (!new_wen && !old_wen) begin
            AST_NO_WRITER_NO_FWD: assert (sel == FWD_RF) else $error("forwarding with no writer"); // R6
        end
        if (new_wen && (new_dst == src) && (src != '0)) begin
            AST_NEWER_WINS: assert (sel == FWD_NEW) else $error("qualifying newer stage not chosen"); // R4
        end
        AST_OUT_FOLLOWS_SEL: assert (out_val == ((sel == FWD_NEW) ? new_val : (sel == FWD_OLD) ? old_val : rf_val)) else $error("operand does not match select"); // R8
    end

endmodule

// File: rtl/operand_forward.sv
module operand_forward
    import fwd_pkg::*;
#(
    parameter int REG_W  = 5,
    parameter int DATA_W = 32
) (
    input  logic [REG_W-1:0]  ex_src_a,
    input  logic [REG_W-1:0]  ex_src_b,
    input  logic              new_wen,
    input  logic [REG_W-1:0]  new_dst,
    input  logic [DATA_W-1:0] new_val,
    input  logic              old_wen,
    input  logic [REG_W-1:0]  old_dst,
    input  logic [DATA_W-1:0] old_val,
    input  logic [DATA_W-1:0] rf_val_a,
    input  logic [DATA_W-1:0] rf_val_b,
    output logic [1:0]        sel_a,
    output logic [1:0]        sel_b,
    output logic [DATA_W-1:0] opnd_a,
    output logic [DATA_W-1:0] opnd_b
);

    typedef struct packed {
        logic [REG_W-1:0]  src;
        logic [DATA_W-1:0] rf;
    } opnd_in_t;

    opnd_in_t          in_d   [NUM_OPND];
    fwd_sel_e          sel_d  [NUM_OPND];
    logic [DATA_W-1:0] val_d  [NUM_OPND];

    always_comb begin
        in_d[0].src = ex_src_a;
        in_d[0].rf  = rf_val_a;
        in_d[1].src = ex_src_b;
        in_d[1].rf  = rf_val_b;
    end

    for (genvar g = 0; g < NUM_OPND; g++) begin : g_opnd
        fwd_operand #(
            .REG_W  (REG_W),
            .DATA_W (DATA_W)
        ) u_opnd (
            .src     (in_d[g].src),
            .new_wen (new_wen),
            .new_dst (new_dst),
            .new_val (new_val),
            .old_wen (old_wen),
            .old_dst (old_dst),
            .old_val (old_val),
            .rf_val  (in_d[g].rf),
            .sel     (sel_d[g]),
            .out_val (val_d[g])
        );
    end

    assign sel_a  = sel_d[0];
    assign sel_b  = sel_d[1];
    assign opnd_a = val_d[0];
    assign opnd_b = val_d[1];

    always_comb begin
        AST_SEL_A_LEGAL: assert (sel_a != 2'b11) else $error("illegal select on A"); // R7
        AST_SEL_B_LEGAL: assert (sel_b != 2'b11) else $error("illegal select on B"); // R3
        if ((ex_src_a == ex_src_b)) begin
            AST_SAME_SRC_SAME_SEL: assert (sel_a == sel_b) else $error("identical sources disagree"); // R9
        end
    end

endmodule

// File: tb/operand_forward_test.sv
module operand_forward_test;

    logic        clk = 1'b0;
    always #5 clk = ~clk;

    logic [4:0]  ex_src_a, ex_src_b, new_dst, old_dst;
    logic        new_wen, old_wen;
    logic [31:0] new_val, old_val, rf_val_a, rf_val_b;
    logic [1:0]  sel_a, sel_b;
    logic [31:0] opnd_a, opnd_b;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    operand_forward uut (
        .ex_src_a (ex_src_a), .ex_src_b (ex_src_b),
        .new_wen  (new_wen),  .new_dst  (new_dst), .new_val (new_val),
        .old_wen  (old_wen),  .old_dst  (old_dst), .old_val (old_val),
        .rf_val_a (rf_val_a), .rf_val_b (rf_val_b),
        .sel_a    (sel_a),    .sel_b    (sel_b),
        .opnd_a   (opnd_a),   .opnd_b   (opnd_b)
    );

    typedef struct packed {
        logic [4:0] a;
        logic [4:0] b;
        logic       nw;
        logic [4:0] nd;
        logic       ow;
        logic [4:0] od;
        logic [1:0] ea;
        logic [1:0] eb;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        '{5'd1,  5'd2,  1'b0, 5'd0,  1'b0, 5'd0,  2'b00, 2'b00}, // R7 nothing in flight
        '{5'd3,  5'd4,  1'b1, 5'd3,  1'b0, 5'd0,  2'b10, 2'b00}, // R1
        '{5'd3,  5'd4,  1'b1, 5'd4,  1'b0, 5'd0,  2'b00, 2'b10}, // R3 newer on B
        '{5'd5,  5'd6,  1'b0, 5'd0,  1'b1, 5'd5,  2'b01, 2'b00}, // R2
        '{5'd5,  5'd6,  1'b0, 5'd0,  1'b1, 5'd6,  2'b00, 2'b01}, // R3 older on B
        '{5'd7,  5'd7,  1'b1, 5'd7,  1'b1, 5'd7,  2'b10, 2'b10}, // R4 both stages match
        '{5'd8,  5'd9,  1'b1, 5'd8,  1'b1, 5'd9,  2'b10, 2'b01}, // R9 crossed
        '{5'd8,  5'd9,  1'b1, 5'd9,  1'b1, 5'd8,  2'b01, 2'b10}, // R9 crossed other way
        '{5'd0,  5'd0,  1'b1, 5'd0,  1'b1, 5'd0,  2'b00, 2'b00}, // R5 register zero
        '{5'd10, 5'd11, 1'b0, 5'd10, 1'b0, 5'd11, 2'b00, 2'b00}, // R6 writers disabled
        '{5'd12, 5'd12, 1'b0, 5'd12, 1'b1, 5'd12, 2'b01, 2'b01}, // R6 disabled newer does not shadow
        '{5'd13, 5'd14, 1'b1, 5'd0,  1'b1, 5'd13, 2'b01, 2'b00}, // R5 newer dst zero does not shadow
        '{5'd31, 5'd30, 1'b1, 5'd31, 1'b1, 5'd30, 2'b10, 2'b01}, // R1 R3 top register
        '{5'd15, 5'd16, 1'b1, 5'd17, 1'b1, 5'd18, 2'b00, 2'b00}  // R7 no match
    };

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] pick(input logic [1:0] s, input logic [31:0] rf);
        return (s == 2'b10) ? new_val : (s == 2'b01) ? old_val : rf;
    endfunction

    task automatic drive(input logic [4:0] a, input logic [4:0] b, input logic nw, input logic [4:0] nd,
                         input logic ow, input logic [4:0] od, input int tag);
        @(posedge clk);
        ex_src_a = a;   ex_src_b = b;
        new_wen  = nw;  new_dst  = nd;
        old_wen  = ow;  old_dst  = od;
        new_val  = 32'hA500_0000 + tag;
        old_val  = 32'h5A00_0000 + tag;
        rf_val_a = 32'hC300_0000 + tag;
        rf_val_b = 32'h3C00_0000 + tag;
        @(negedge clk);
    endtask

    task automatic expect_both(input logic [1:0] ea, input logic [1:0] eb, input string req);
        check(sel_a == ea, {req, " sel_a"}, 32'(sel_a), 32'(ea));
        check(sel_b == eb, {req, " sel_b"}, 32'(sel_b), 32'(eb));
        check(opnd_a == pick(ea, rf_val_a), {"R8 opnd_a ", req}, opnd_a, pick(ea, rf_val_a));
        check(opnd_b == pick(eb, rf_val_b), {"R8 opnd_b ", req}, opnd_b, pick(eb, rf_val_b));
    endtask

    initial begin
        // Idle state: everything zero, file values pass through (R7)
        drive(5'd0, 5'd0, 1'b0, 5'd0, 1'b0, 5'd0, 0);
        expect_both(2'b00, 2'b00, "R7 idle");

        // Table walk covering R1 R2 R3 R4 R5 R6 R7 R9
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i].a, VEC[i].b, VEC[i].nw, VEC[i].nd, VEC[i].ow, VEC[i].od, i + 1);
            expect_both(VEC[i].ea, VEC[i].eb, $sformatf("table row %0d (R1 R2 R3 R4 R5 R6 R7 R9)", i));
        end

        // Sweep every register number through each stage alone (R1 R2 R5)
        for (int r = 0; r < 32; r++) begin
            drive(5'(r), 5'(31 - r), 1'b1, 5'(r), 1'b0, 5'(r), 100 + r);
            expect_both((r != 0) ? 2'b10 : 2'b00, 2'b00, $sformatf("R1 R5 newer sweep r=%0d", r));
            drive(5'(r), 5'(31 - r), 1'b0, 5'(r), 1'b1, 5'(r), 200 + r);
            expect_both((r != 0) ? 2'b01 : 2'b00, 2'b00, $sformatf("R2 R5 older sweep r=%0d", r));
        end

        // Accumulating chain: both stages target the source (R4)
        drive(5'd1, 5'd2, 1'b1, 5'd1, 1'b1, 5'd1, 300);
        expect_both(2'b10, 2'b00, "R4 chain");

        // Combinational response: change inputs, observe after a short delay (R10)
        @(posedge clk);
        #2;
        new_dst = 5'd2;
        #1;
        check(sel_b == 2'b10, "R10 sel_b mid-cycle", 32'(sel_b), 32'h2);
        check(opnd_b == new_val, "R10 opnd_b mid-cycle", opnd_b, new_val);
        check(sel_a == 2'b01, "R10 sel_a mid-cycle", 32'(sel_a), 32'h1);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule